// File: doc/BRIEF.md
# Miscellaneous Interrupt Aggregator

This block merges up to 32 level-sensitive peripheral interrupt lines into one request for a parent interrupt controller. Each source passes through a short synchronizer and then reaches a per-line status bit. A per-line enable word masks these bits. The parent request is high whenever at least one line is both pending and enabled.

Software reaches the block through a minimal register port made of an address, a write strobe, write data, a read strobe and read data. To acknowledge a line, software reads the status word, clears the serviced bit, and writes the word back. A 0 clears a bit and a 1 leaves it as it was. A build-time mode chooses between two status behaviours. In the latched mode each bit is sticky until it is cleared. In the live mode the status word simply shows the synchronized source levels.

Line 5 is usually given to the processor's performance-counter overflow. The hardware treats it exactly like every other line.

Top module: `misc_irq_aggr`

## Requirements
- R1: Source line i, for every i from 0 to 31 and including line 5, drives only bit i of the status word. After an active pulse of at least one cycle, bit i is set once SYNC_STAGES+1 clock edges have passed.
- R2: The status word is at byte address 0x0 and the enable word at 0x4. Read data is zero while the read strobe is low, and a read of any other address returns zero.
- R3: irq_o is high exactly when the bitwise AND of the status word and the enable word is nonzero.
- R4: A write to 0x4 replaces the whole enable word. Every enable bit reads back its last written value.
- R5: In latched mode, writing a 0 to a status bit whose source is inactive clears that bit.
- R6: In latched mode, writing a 1 to a status bit leaves that bit unchanged, whether it was set or clear.
- R7: In latched mode, a line whose source is still active after it was cleared reads as pending again.
- R8: In latched mode, if a synchronized source is active on the same edge as a write that clears its bit, the bit stays set.
- R9: In live mode, the status word reads the synchronized source levels, and writes to 0x0 have no effect.
- R10: A synchronous active-high reset sets the status and enable words to zero and holds irq_o low.
- R11: With all sources inactive, writing 0 to the enable word and then 0 to the status word leaves both words at zero and irq_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Asynchronous level interrupt sources |
| addr_i | input | ADDR_W | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Read data, combinational while rd_en_i is high |
| irq_o | output | 1 | Request to the parent controller |

## Verification
The collision that matters is a status write that clears a bit on the same clock edge where the synchronized source for that bit first shows as active. The bench sets up this collision with a one-cycle source pulse. The pulse is timed so that the synchronizer output is high only on the edge where the clearing write is applied, so the event is seen on that one edge and never again. The bench passes the design only if the bit still reads as set afterwards, because a design that let the clear win would lose the event for good.

// File: rtl/misc_irq_pkg.sv
package misc_irq_pkg;
   localparam int unsigned STAT_OFS = 0;
   localparam int unsigned EN_OFS   = 4;

   typedef enum logic {
      ST_LATCH = 1'b0,
      ST_LIVE  = 1'b1
   } stat_mode_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   initial begin
      if (STAGES < 1) $error("irq_sync: STAGES must be at least 1");
   end

   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
      end else begin
         pipe[0] <= d_i;
         for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      end
   end

   assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/irq_stat_reg.sv
module irq_stat_reg
   import misc_irq_pkg::*;
#(
   parameter int unsigned W    = 32,
   parameter stat_mode_e  MODE = ST_LATCH
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] src_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] stat_o
);
   generate
      if (MODE == ST_LATCH) begin : g_latch
         logic [W-1:0] stat_q;

         always_ff @(posedge clk) begin
            if (rst) stat_q <= '0;
            else if (wr_i) stat_q <= (stat_q & wdata_i) | src_i;
            else stat_q <= stat_q | src_i;
         end

         assign stat_o = stat_q;

         // R8
         set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            (src_i != '0) |=> ((stat_q & $past(src_i)) == $past(src_i)));
         // R6
         ones_keep_chk: assert property (@(posedge clk) disable iff (rst)
            wr_i |=> (($past(stat_q) & $past(wdata_i) & ~stat_q) == '0));
         // R5
         zero_clears_chk: assert property (@(posedge clk) disable iff (rst)
            wr_i |=> ((stat_q & ~$past(wdata_i) & ~$past(src_i)) == '0));
         // R7
         no_loss_chk: assert property (@(posedge clk) disable iff (rst)
            !wr_i |=> (($past(stat_q) & ~stat_q) == '0));
      end else begin : g_live
         logic unused_wr;
         assign unused_wr = wr_i ^ (^wdata_i) ^ clk ^ rst;
         assign stat_o    = src_i;
      end
   endgenerate
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] en_o
);
   logic [W-1:0] en_q;

   always_ff @(posedge clk) begin
      if (rst) en_q <= '0;
      else if (wr_i) en_q <= wdata_i;
   end

   assign en_o = en_q;

   // R4
   en_load_chk: assert property (@(posedge clk) disable iff (rst)
      wr_i |=> (en_q == $past(wdata_i)));
   // R4
   en_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_i |=> $stable(en_q));
endmodule

// File: rtl/misc_irq_aggr.sv
module misc_irq_aggr
   import misc_irq_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter stat_mode_e  MODE        = ST_LATCH
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               wr_en_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic               rd_en_i,
   output logic [DATA_W-1:0]  rdata_o,
   output logic               irq_o
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_OFS);

   initial begin
      if (NUM_SRC < 1 || NUM_SRC > 32) $error("misc_irq_aggr: NUM_SRC out of range");
      if (DATA_W < NUM_SRC) $error("misc_irq_aggr: DATA_W below NUM_SRC");
      if (ADDR_W < 3) $error("misc_irq_aggr: ADDR_W too small for register map");
      if (SYNC_STAGES < 1) $error("misc_irq_aggr: SYNC_STAGES must be at least 1");
   end

   logic [NUM_SRC-1:0] src_sync;
   logic [NUM_SRC-1:0] stat;
   logic [NUM_SRC-1:0] en;
   logic               hit_stat, hit_en;
   logic [DATA_W-1:0]  stat_ext, en_ext;

   assign hit_stat = (addr_i == A_STAT);
   assign hit_en   = (addr_i == A_EN);

   irq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (src_i),
      .q_o (src_sync)
   );

   irq_stat_reg #(.W(NUM_SRC), .MODE(MODE)) u_stat (
      .clk     (clk),
      .rst     (rst),
      .src_i   (src_sync),
      .wr_i    (wr_en_i && hit_stat),
      .wdata_i (wdata_i[NUM_SRC-1:0]),
      .stat_o  (stat)
   );

   irq_en_reg #(.W(NUM_SRC)) u_en (
      .clk     (clk),
      .rst     (rst),
      .wr_i    (wr_en_i && hit_en),
      .wdata_i (wdata_i[NUM_SRC-1:0]),
      .en_o    (en)
   );

   always_comb begin
      stat_ext = '0;
      en_ext   = '0;
      stat_ext[NUM_SRC-1:0] = stat;
      en_ext[NUM_SRC-1:0]   = en;
   end

   always_comb begin
      rdata_o = '0;
      if (rd_en_i) begin
         if (hit_stat) rdata_o = stat_ext;
         else if (hit_en) rdata_o = en_ext;
      end
   end

   assign irq_o = |(stat & en);

   // R10
   reset_quiet_chk: assert property (@(posedge clk)
      $past(rst) |-> !irq_o);
   // R2
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (!rd_en_i || (!hit_stat && !hit_en)) |-> (rdata_o == '0));
endmodule

// File: tb/sim_misc_irq_aggr.sv
module sim_misc_irq_aggr;
   import misc_irq_pkg::*;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] src = '0;
   logic [3:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rdata0, rdata1;
   logic        irq0, irq1;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   misc_irq_aggr #(.MODE(ST_LATCH)) u0 (
      .clk(clk), .rst(rst), .src_i(src), .addr_i(addr), .wr_en_i(wr_en),
      .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata0), .irq_o(irq0));

   misc_irq_aggr #(.MODE(ST_LIVE)) u1 (
      .clk(clk), .rst(rst), .src_i(src), .addr_i(addr), .wr_en_i(wr_en),
      .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata1), .irq_o(irq1));

   function automatic logic want_irq(input logic [31:0] s, input logic [31:0] e);
      return |(s & e);
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d0, output logic [31:0] d1);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1;
      d0 = rdata0; d1 = rdata1;
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [31:0] r0, r1, exp_s, en;
      void'($urandom(32'h5EED_0017));
      idle(3);
      @(negedge clk) rst = 1'b0;

      // R10 reset state
      rd(4'h0, r0, r1); chk("R10 stat", r0, 32'h0);
      rd(4'h4, r0, r1); chk("R10 en", r0, 32'h0);
      chk("R10 irq", {31'b0, irq0}, 32'h0);

      // R2 unmapped and idle reads
      wr(4'h4, 32'hA5A5_0F0F);
      rd(4'h8, r0, r1); chk("R2 unmapped", r0, 32'h0);
      rd(4'hC, r0, r1); chk("R2 unmapped live", r1, 32'h0);
      @(negedge clk); #1; chk("R2 rd_en low", rdata0, 32'h0);
      rd(4'h4, r0, r1); chk("R4 readback", r0, 32'hA5A5_0F0F);
      wr(4'h4, 32'h0);

      // R1 line 5 pulse, latency SYNC_STAGES+1 edges
      @(negedge clk) src[5] = 1'b1;
      @(negedge clk) src[5] = 1'b0;
      @(negedge clk);
      rd(4'h0, r0, r1); chk("R1 line5", r0, 32'h0000_0020);
      chk("R3 masked", {31'b0, irq0}, 32'h0);
      wr(4'h4, 32'h0000_0020);
      #1 chk("R3 enabled", {31'b0, irq0}, 32'h1);

      // R1 line 3 and R5/R6 clear with write-back
      @(negedge clk) src[3] = 1'b1;
      @(negedge clk) src[3] = 1'b0;
      idle(3);
      rd(4'h0, r0, r1); chk("R1 line3", r0, 32'h0000_0028);
      wr(4'h0, 32'hFFFF_FFF7);
      rd(4'h0, r0, r1); chk("R5 R6 clear one", r0, 32'h0000_0020);
      wr(4'h0, 32'hFFFF_FFDF);
      rd(4'h0, r0, r1); chk("R5 cleared", r0, 32'h0);
      chk("R3 none", {31'b0, irq0}, 32'h0);

      // R7 held source returns after clear
      @(negedge clk) src[12] = 1'b1;
      idle(4);
      wr(4'h0, 32'h0);
      rd(4'h0, r0, r1); chk("R7 repend", r0, 32'h0000_1000);
      @(negedge clk) src[12] = 1'b0;
      idle(4);
      wr(4'h0, 32'h0);

      // R8 set wins over clear on the same edge
      @(negedge clk) src[7] = 1'b1;
      @(negedge clk) src[7] = 1'b0;
      idle(3);
      rd(4'h0, r0, r1); chk("R8 pre", r0, 32'h0000_0080);
      @(negedge clk) src[7] = 1'b1;
      @(negedge clk) src[7] = 1'b0;
      @(negedge clk) begin addr = 4'h0; wdata = 32'hFFFF_FF7F; wr_en = 1'b1; end
      @(negedge clk) wr_en = 1'b0;
      idle(3);
      rd(4'h0, r0, r1); chk("R8 race", r0, 32'h0000_0080);
      wr(4'h0, 32'h0);
      rd(4'h0, r0, r1); chk("R5 after race", r0, 32'h0);

      // R9 live mode ignores writes, follows levels
      @(negedge clk) src = 32'h8000_0101;
      idle(3);
      wr(4'h0, 32'h0);
      rd(4'h0, r0, r1); chk("R9 level", r1, 32'h8000_0101);
      @(negedge clk) src = 32'h0;
      idle(3);
      wr(4'h0, 32'hFFFF_FFFF);
      rd(4'h0, r0, r1); chk("R9 write ignored", r1, 32'h0);
      wr(4'h0, 32'h0);

      // random mix, model from requirements
      exp_s = 32'h0;
      for (int it = 0; it < 60; it++) begin
         logic [31:0] s, w;
         en = $urandom;
         s  = (it % 4 == 3) ? 32'h0 : ($urandom & $urandom);
         w  = $urandom;
         wr(4'h4, en);
         @(negedge clk) src = s;
         idle(4);
         exp_s = exp_s | s;
         rd(4'h0, r0, r1);
         chk("R1 rand stat", r0, exp_s);
         chk("R9 rand live", r1, s);
         chk("R3 rand irq", {31'b0, irq0}, {31'b0, want_irq(exp_s, en)});
         chk("R3 rand irq live", {31'b0, irq1}, {31'b0, want_irq(s, en)});
         wr(4'h0, w);
         exp_s = (exp_s & w) | s;
         rd(4'h0, r0, r1); chk("R5 R6 R7 rand clear", r0, exp_s);
         rd(4'h4, r0, r1); chk("R4 rand en", r0, en);
      end

      // R11 init sequence
      @(negedge clk) src = 32'h0;
      idle(4);
      wr(4'h4, 32'h0);
      wr(4'h0, 32'h0);
      rd(4'h0, r0, r1); chk("R11 stat", r0, 32'h0);
      rd(4'h4, r0, r1); chk("R11 en", r0, 32'h0);
      chk("R11 irq", {30'b0, irq1, irq0}, 32'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule